// File: doc/BRIEF.md
# Two-Wire Register Access Port

This block is a target on a two-wire serial control bus. It gives a host controller read and write access to a block of on-chip registers. The lines arrive as plain inputs. The data line is pulled low through an open-drain enable, so the host and the target share it as a wired-AND bus. Inside the chip, the block talks to the register file over a parallel port. That port has a one-cycle write strobe and a combinational read path addressed by a pointer.

Each transfer begins with a 7-bit target address and a direction bit. A write then carries a subaddress byte followed by data bytes. A read first sets the subaddress with a short write, then issues a repeated start with the read bit set. Most registers are one byte wide. A parameterised window of subaddresses holds 32-bit coefficient words. These are moved MSB first, and only the lower 26 bits are kept. The target address sits in a local register that is not part of the register file, so the host can move the device to a new address while the system runs.

Top module: `i2c_reg_port`

## Requirements
- R1: While reset is asserted and afterwards until a transfer starts, the data-line pull-down is off and no register write strobe is issued. The active target address after reset is 0x36.
- R2: The block drives an acknowledge (data line low during the ninth clock) only for an address byte whose upper seven bits equal the active address. A byte with any other address gets no acknowledge, and the rest of that transfer causes no register write.
- R3: A write of subaddress S followed by a data byte D to a one-byte register produces exactly one write strobe, with address S and data D zero-extended to 32 bits.
- R4: After each one-byte register access, whether a write or a read, the subaddress pointer advances by one. Consecutive data bytes in one transfer therefore reach S, S+1, S+2 and so on.
- R5: Subaddresses 0x29 to 0x4F are 32-bit registers taking four bytes, most significant first. One write strobe is issued only after the fourth byte has been acknowledged and the data line released. Bits 31 to 26 of the written word are zero.
- R6: A read returns, MSB first, the byte the register file presents at the pointer. A one-byte register gives bits 7 to 0. A 32-bit register gives four bytes from bits 31 to 24 down to bits 7 to 0, all from one snapshot taken at its first byte. The pointer then moves on.
- R7: When the host answers a read byte with no acknowledge, the block stops driving the data line. It stays off for all further clocks until the next start condition.
- R8: Subaddress 0xF9 holds the active address. Writing a byte to it makes bits 6 to 0 of that byte the new address. The write is not passed to the register-file port. Reading 0xF9 returns the active address.
- R9: The block changes its data-line drive only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples both bus lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | Pulls the data line low when high |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 8 | Subaddress of the register being written |
| wr_data_o | output | 32 | Value written, zero-extended or masked |
| rd_addr_o | output | 8 | Current subaddress pointer for reads |
| rd_data_i | input | 32 | Register contents at rd_addr_o, combinational |

## Verification
The bench moves the bus clock in quarter periods of ten system cycles. Each line change reaches the control logic after a two-flop synchroniser and an edge detector, so about three cycles. Any drive change follows one cycle after that. A result is therefore settled well inside the ten-cycle quarter that follows the edge causing it. Acknowledge and read data bits are sampled halfway through the clock-high phase, at the system falling edge. Register writes are checked after the following stop condition, which comes at least two quarters after the acknowledge clock edge that produces the strobe. Write-strobe counts are compared both before and after the last byte of a 32-bit register.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    LK_IDLE,
    LK_ADDR,
    LK_AACK,
    LK_WDATA,
    LK_WACK,
    LK_RDATA,
    LK_RACK,
    LK_RNEXT
  } link_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe_q, sda_pipe_q;
  logic scl_prev_q, sda_prev_q;
  logic scl_s, sda_s;

  assign scl_s = scl_pipe_q[STAGES-1];
  assign sda_s = sda_pipe_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_i};
      sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_i};
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  assign sda_s_o    = sda_s;
  assign scl_rise_o = scl_s & ~scl_prev_q;
  assign scl_fall_o = ~scl_s & scl_prev_q;
  // data edges while the clock stays high mark frame boundaries
  assign start_o    = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign stop_o     = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/i2c_link.sv
module i2c_link
  import i2c_reg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        scl_rise_i,
  input  logic        scl_fall_i,
  input  logic        sda_i,
  input  logic        start_i,
  input  logic        stop_i,
  input  logic [6:0]  dev_addr_i,
  input  logic [7:0]  tx_byte_i,
  output logic        sda_oe_o,
  output logic        rx_valid_o,
  output logic        rx_first_o,
  output logic [7:0]  rx_byte_o,
  output logic        tx_load_o
);
  link_state_t st_q, st_d;
  logic [3:0]  cnt_q, cnt_d;
  logic [7:0]  sh_q, sh_d;
  logic        rw_q, rw_d;
  logic        first_q, first_d;
  logic        oe_q, oe_d;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; sh_d = sh_q; rw_d = rw_q;
    first_d = first_q; oe_d = oe_q;
    rx_valid_o = 1'b0;
    tx_load_o  = 1'b0;
    if (start_i) begin
      st_d = LK_ADDR; cnt_d = '0; oe_d = 1'b0;
    end else if (stop_i) begin
      st_d = LK_IDLE; oe_d = 1'b0;
    end else begin
      unique case (st_q)
        LK_ADDR: begin
          if (scl_rise_i) begin
            sh_d = {sh_q[6:0], sda_i}; cnt_d = cnt_q + 4'd1;
          end else if (scl_fall_i && cnt_q == 4'd8) begin
            if (sh_q[7:1] == dev_addr_i) begin
              oe_d = 1'b1; rw_d = sh_q[0]; first_d = ~sh_q[0]; st_d = LK_AACK;
            end else begin
              st_d = LK_IDLE;
            end
          end
        end
        LK_AACK: if (scl_fall_i) begin
          cnt_d = '0;
          if (rw_q) begin
            tx_load_o = 1'b1; sh_d = tx_byte_i; oe_d = ~tx_byte_i[7]; st_d = LK_RDATA;
          end else begin
            oe_d = 1'b0; st_d = LK_WDATA;
          end
        end
        LK_WDATA: begin
          if (scl_rise_i) begin
            sh_d = {sh_q[6:0], sda_i}; cnt_d = cnt_q + 4'd1;
          end else if (scl_fall_i && cnt_q == 4'd8) begin
            oe_d = 1'b1; st_d = LK_WACK;
          end
        end
        LK_WACK: if (scl_fall_i) begin
          oe_d = 1'b0; cnt_d = '0; rx_valid_o = 1'b1; first_d = 1'b0; st_d = LK_WDATA;
        end
        LK_RDATA: begin
          if (scl_rise_i) begin
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall_i) begin
            if (cnt_q == 4'd8) begin
              oe_d = 1'b0; st_d = LK_RACK;
            end else begin
              sh_d = {sh_q[6:0], 1'b0}; oe_d = ~sh_q[6];
            end
          end
        end
        LK_RACK: if (scl_rise_i) st_d = sda_i ? LK_IDLE : LK_RNEXT;
        LK_RNEXT: if (scl_fall_i) begin
          tx_load_o = 1'b1; sh_d = tx_byte_i; oe_d = ~tx_byte_i[7];
          cnt_d = '0; st_d = LK_RDATA;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= LK_IDLE; cnt_q <= '0; sh_q <= '0; rw_q <= 1'b0;
      first_q <= 1'b0; oe_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; sh_q <= sh_d; rw_q <= rw_d;
      first_q <= first_d; oe_q <= oe_d;
    end
  end

  assign sda_oe_o   = oe_q;
  assign rx_first_o = first_q;
  assign rx_byte_o  = sh_q;
endmodule

// File: rtl/i2c_reg_map.sv
module i2c_reg_map #(
  parameter logic [6:0] DEF_ADDR  = 7'h36,
  parameter logic [7:0] ADDR_REG  = 8'hF9,
  parameter logic [7:0] WIDE_LO   = 8'h29,
  parameter logic [7:0] WIDE_HI   = 8'h4F,
  parameter int         DATA_W    = 32,
  parameter int         USED_BITS = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              rx_valid_i,
  input  logic              rx_first_i,
  input  logic [7:0]        rx_byte_i,
  input  logic              tx_load_i,
  output logic [7:0]        tx_byte_o,
  output logic [6:0]        dev_addr_o,
  output logic              wr_en_o,
  output logic [7:0]        wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [7:0]        rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i
);
  localparam int NBYTES = DATA_W / 8;
  localparam int IDX_W  = $clog2(NBYTES);
  localparam logic [DATA_W-1:0] USED_MASK =
    {{(DATA_W-USED_BITS){1'b0}}, {USED_BITS{1'b1}}};

  logic [7:0]        ptr_q, ptr_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] acc_q, acc_d, word_q, word_d;
  logic [6:0]        addr_q, addr_d;
  logic              wen_q, wen_d;
  logic [7:0]        wad_q, wad_d;
  logic [DATA_W-1:0] wdt_q, wdt_d;

  logic              wide, last;
  logic [DATA_W-1:0] src, cur, shifted;

  assign wide    = (ptr_q >= WIDE_LO) && (ptr_q <= WIDE_HI);
  assign last    = !wide || (idx_q == IDX_W'(NBYTES-1));
  assign src     = (ptr_q == ADDR_REG) ? DATA_W'(addr_q) : rd_data_i;
  assign cur     = (idx_q == '0) ? src : word_q;
  assign shifted = cur << (8 * idx_q);
  assign tx_byte_o = wide ? shifted[DATA_W-1 -: 8] : cur[7:0];

  always_comb begin
    ptr_d = ptr_q; idx_d = idx_q; acc_d = acc_q; word_d = word_q;
    addr_d = addr_q; wen_d = 1'b0; wad_d = wad_q; wdt_d = wdt_q;
    if (frame_start_i) begin
      idx_d = '0;
    end else if (rx_valid_i) begin
      if (rx_first_i) begin
        ptr_d = rx_byte_i; idx_d = '0;
      end else if (!last) begin
        acc_d = {acc_q[DATA_W-9:0], rx_byte_i}; idx_d = idx_q + 1'b1;
      end else begin
        if (ptr_q == ADDR_REG) begin
          addr_d = rx_byte_i[6:0];
        end else begin
          wen_d = 1'b1; wad_d = ptr_q;
          wdt_d = wide ? ({acc_q[DATA_W-9:0], rx_byte_i} & USED_MASK)
                       : DATA_W'(rx_byte_i);
        end
        ptr_d = ptr_q + 8'd1; idx_d = '0;
      end
    end else if (tx_load_i) begin
      if (idx_q == '0) word_d = src;
      if (!last) idx_d = idx_q + 1'b1;
      else begin ptr_d = ptr_q + 8'd1; idx_d = '0; end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0; idx_q <= '0; acc_q <= '0; word_q <= '0;
      addr_q <= DEF_ADDR; wen_q <= 1'b0; wad_q <= '0; wdt_q <= '0;
    end else begin
      ptr_q <= ptr_d; idx_q <= idx_d; acc_q <= acc_d; word_q <= word_d;
      addr_q <= addr_d; wen_q <= wen_d; wad_q <= wad_d; wdt_q <= wdt_d;
    end
  end

  assign dev_addr_o = addr_q;
  assign wr_en_o    = wen_q;
  assign wr_addr_o  = wad_q;
  assign wr_data_o  = wdt_q;
  assign rd_addr_o  = ptr_q;
endmodule

// File: rtl/i2c_reg_port.sv
module i2c_reg_port #(
  parameter logic [6:0] DEF_ADDR    = 7'h36,
  parameter logic [7:0] ADDR_REG    = 8'hF9,
  parameter logic [7:0] WIDE_LO     = 8'h29,
  parameter logic [7:0] WIDE_HI     = 8'h4F,
  parameter int         DATA_W      = 32,
  parameter int         USED_BITS   = 26,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [7:0]        wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [7:0]        rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i
);
  logic [1:0] rst_pipe_q;
  logic       rst_n;
  logic       sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic       rx_valid, rx_first, tx_load;
  logic [7:0] rx_byte, tx_byte;
  logic [6:0] dev_addr;

  // assert asynchronously, release on a clock edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni(rst_n), .scl_i, .sda_i,
    .sda_s_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_p), .stop_o(stop_p)
  );

  i2c_link u_link (
    .clk_i, .rst_ni(rst_n), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .sda_i(sda_s), .start_i(start_p), .stop_i(stop_p),
    .dev_addr_i(dev_addr), .tx_byte_i(tx_byte), .sda_oe_o,
    .rx_valid_o(rx_valid), .rx_first_o(rx_first), .rx_byte_o(rx_byte),
    .tx_load_o(tx_load)
  );

  i2c_reg_map #(
    .DEF_ADDR(DEF_ADDR), .ADDR_REG(ADDR_REG), .WIDE_LO(WIDE_LO),
    .WIDE_HI(WIDE_HI), .DATA_W(DATA_W), .USED_BITS(USED_BITS)
  ) u_map (
    .clk_i, .rst_ni(rst_n), .frame_start_i(start_p),
    .rx_valid_i(rx_valid), .rx_first_i(rx_first), .rx_byte_i(rx_byte),
    .tx_load_i(tx_load), .tx_byte_o(tx_byte), .dev_addr_o(dev_addr),
    .wr_en_o, .wr_addr_o, .wr_data_o, .rd_addr_o, .rd_data_i
  );
endmodule

// File: rtl/i2c_reg_port_chk.sv
module i2c_reg_port_chk #(
  parameter logic [7:0] ADDR_REG  = 8'hF9,
  parameter logic [7:0] WIDE_LO   = 8'h29,
  parameter logic [7:0] WIDE_HI   = 8'h4F,
  parameter int         DATA_W    = 32,
  parameter int         USED_BITS = 26
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_i,
  input logic              sda_oe_o,
  input logic              wr_en_o,
  input logic [7:0]        wr_addr_o,
  input logic [DATA_W-1:0] wr_data_o
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) reset_quiet_chk: assert (!sda_oe_o && !wr_en_o);
  end

  // R9
  sda_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);

  // R3
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);

  // R5
  coef_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_addr_o >= WIDE_LO && wr_addr_o <= WIDE_HI)
      |-> (wr_data_o[DATA_W-1:USED_BITS] == '0));

  // R5
  commit_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !sda_oe_o);

  // R8
  addr_reg_local_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_addr_o != ADDR_REG));
endmodule

bind i2c_reg_port i2c_reg_port_chk #(
  .ADDR_REG(ADDR_REG), .WIDE_LO(WIDE_LO), .WIDE_HI(WIDE_HI),
  .DATA_W(DATA_W), .USED_BITS(USED_BITS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
);

// File: tb/i2c_reg_port_bench.sv
module i2c_reg_port_bench;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_drv = 1'b1;
  logic sda_oe, wr_en;
  logic [7:0] wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  wire sda_line = sda_drv & ~sda_oe;

  logic [31:0] mem [256];
  int wr_cnt = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  always #4 clk = ~clk;

  i2c_reg_port u_i2c_reg_port (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  assign rd_data = mem[rd_addr];

  initial for (int i = 0; i < 256; i++) mem[i] = 32'h0;

  always @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
      wr_cnt <= wr_cnt + 1;
    end
  end

  function automatic logic [31:0] coef(input logic [7:0] b0, b1, b2, b3);
    return {b0 & 8'h03, b1, b2, b3};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_drv = 1'b1; wq(); scl = 1'b1; wq(); sda_drv = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_drv = 1'b0; wq(); scl = 1'b1; wq(); sda_drv = 1'b1; wq();
  endtask

  task automatic clk_bit(input logic b, output logic r);
    sda_drv = b; wq(); scl = 1'b1; wq(); r = sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic write_byte(input logic [7:0] b, output bit ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, r);
    ack = !r;
  endtask

  task automatic read_byte(input bit ack, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, r); v[i] = r; end
    clk_bit(!ack, r);
  endtask

  task automatic do_write(input logic [6:0] dev, input logic [7:0] sub,
                          input int n, output bit ok);
    bit a;
    i2c_start();
    write_byte({dev, 1'b0}, a); ok = a;
    if (a) begin
      write_byte(sub, a); ok &= a;
      for (int i = 0; i < n; i++) begin write_byte(wbuf[i], a); ok &= a; end
    end
    i2c_stop();
  endtask

  task automatic do_read(input logic [6:0] dev, input logic [7:0] sub,
                         input int n, output bit ok);
    bit a;
    i2c_start();
    write_byte({dev, 1'b0}, a); ok = a;
    write_byte(sub, a); ok &= a;
    i2c_start();
    write_byte({dev, 1'b1}, a); ok &= a;
    for (int i = 0; i < n; i++) read_byte(i != n - 1, rbuf[i]);
    i2c_stop();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    bit ok, a;
    logic r;
    int base;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    // R1 during reset
    chk("R1 oe in reset", {31'd0, sda_oe}, 32'd0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1 oe after reset", {31'd0, sda_oe}, 32'd0);
    chk("R1 no strobe", wr_cnt, 0);

    // R3 single-byte write; R2 acknowledge on default address
    wbuf[0] = 8'hA5;
    do_write(7'h36, 8'h05, 1, ok);
    chk("R2 ack default addr", {31'd0, ok}, 32'd1);
    chk("R3 data", mem[8'h05], 32'h0000_00A5);
    chk("R3 one strobe", wr_cnt, 1);

    // R4 burst with auto increment
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(7'h36, 8'h10, 3, ok);
    chk("R4 byte0", mem[8'h10], 32'h11);
    chk("R4 byte1", mem[8'h11], 32'h22);
    chk("R4 byte2", mem[8'h12], 32'h33);

    // R5 wide register: no strobe before fourth byte, masked after
    base = wr_cnt;
    i2c_start();
    write_byte({7'h36, 1'b0}, a);
    write_byte(8'h30, a);
    write_byte(8'hFF, a); write_byte(8'h12, a); write_byte(8'h34, a);
    chk("R5 no early strobe", wr_cnt, base);
    write_byte(8'h56, a);
    i2c_stop();
    chk("R5 one strobe", wr_cnt, base + 1);
    chk("R5 masked word", mem[8'h30], coef(8'hFF, 8'h12, 8'h34, 8'h56));

    // R6 reads of single and wide registers
    do_read(7'h36, 8'h05, 1, ok);
    chk("R6 single read", {24'd0, rbuf[0]}, 32'hA5);
    do_read(7'h36, 8'h10, 3, ok);
    chk("R6 R4 read inc", {8'd0, rbuf[0], rbuf[1], rbuf[2]}, 32'h112233);
    mem[8'h31] = 32'hDEAD_BEEF;
    do_read(7'h36, 8'h30, 8, ok);
    chk("R6 wide read", {rbuf[0], rbuf[1], rbuf[2], rbuf[3]}, 32'h0312_3456);
    chk("R6 wide next", {rbuf[4], rbuf[5], rbuf[6], rbuf[7]}, 32'hDEAD_BEEF);

    // R7 master NACK releases the line until next start
    i2c_start();
    write_byte({7'h36, 1'b0}, a); write_byte(8'h05, a);
    i2c_start();
    write_byte({7'h36, 1'b1}, a);
    read_byte(1'b0, rbuf[0]);
    begin
      logic [8:0] seen;
      for (int i = 0; i < 9; i++) begin clk_bit(1'b1, r); seen[i] = r; end
      chk("R7 released after nack", {23'd0, seen}, 32'h1FF);
    end
    i2c_stop();

    // R2 foreign address gets no ack, no write
    base = wr_cnt;
    wbuf[0] = 8'h77;
    do_write(7'h37, 8'h05, 1, ok);
    chk("R2 no ack foreign", {31'd0, ok}, 32'd0);
    chk("R2 no write foreign", wr_cnt, base);

    // R8 relocate the target address
    wbuf[0] = 8'h38;
    do_write(7'h36, 8'hF9, 1, ok);
    chk("R8 not forwarded", wr_cnt, base);
    wbuf[0] = 8'h5A;
    do_write(7'h36, 8'h06, 1, ok);
    chk("R8 old addr ignored", {31'd0, ok}, 32'd0);
    do_write(7'h38, 8'h06, 1, ok);
    chk("R8 new addr write", mem[8'h06], 32'h5A);
    do_read(7'h38, 8'hF9, 1, ok);
    chk("R8 readback", {24'd0, rbuf[0]}, 32'h38);

    // R4 R6 constrained random bursts on one-byte registers
    for (int it = 0; it < 16; it++) begin
      int n;
      logic [7:0] sub;
      sub = 8'($urandom_range(0, 32));
      n = $urandom_range(1, 3);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      do_write(7'h38, sub, n, ok);
      chk("R4 random ack", {31'd0, ok}, 32'd1);
      for (int i = 0; i < n; i++)
        chk("R4 random write", mem[8'(sub + i)], {24'd0, wbuf[i]});
      do_read(7'h38, sub, n, ok);
      for (int i = 0; i < n; i++)
        chk("R6 random read", {24'd0, rbuf[i]}, {24'd0, wbuf[i]});
    end

    finish_run();
  end
endmodule